// File: doc/BRIEF.md
# Chip Pulse-Shaping Lookup Filter

This block turns a serial stream of spread-spectrum chips into shaped 14-bit DAC samples. Each chip accepted from the upstream spreader enters a short history window. For every chip, the block then plays out a burst of precomputed samples. Each sample is the response of a 54-tap FIR pulse-shaping filter to the last three chips. No multiplier is involved: the window pattern and a sample-phase counter address a constant table of every possible filter output.

The table is generated at elaboration from a parameterised coefficient shape. The shape is a parabolic window whose scale is set by a peak parameter and carries a few fractional bits. Each table word is the polarity-weighted sum of three 18-sample segments of that shape, rounded and clamped to the output width. Upstream logic offers chips with a valid/ready handshake. Downstream logic takes one sample per clock, qualified by a valid strobe.

Top module: `chip_shaper`

## Requirements
- R1: A chip is accepted on a rising clock edge where `chip_valid` and `chip_ready` are both high. On acceptance the 3-bit window shifts right by one: the new chip goes to bit 2, bit 2 moves to bit 1, bit 1 moves to bit 0, and the old bit 0 is dropped. Without an acceptance the window holds.
- R2: For the filter arithmetic, a chip value 0 counts as +1 and a chip value 1 counts as -1.
- R3: The sample at phase p (0..17) is computed as follows. Sum, over segment j = 0, 1, 2, the polarity of window bit (2-j) times coefficient c(18j+p). The newest chip therefore uses taps 0..17 and the oldest uses taps 36..53. Then add 8, shift right arithmetically by 4, and clamp to the range -8192..8191. The result is presented in 14-bit two's complement.
- R4: After an acceptance, `out_valid` is high for exactly 18 consecutive cycles. `out_word` carries phases 0 to 17 in order, starting in the cycle that follows the accepting edge.
- R5: `chip_ready` is high exactly when no burst is running or the burst is in phase 17.
- R6: If no chip is accepted in phase 17, `out_valid` goes low in the next cycle and stays low until a chip is accepted. No burst is repeated.
- R7: Reset leaves the window at 000 and the phase at 0. It also leaves `out_valid` low and `chip_ready` high.
- R8: A chip accepted in phase 17 starts its phase-0 sample in the very next cycle, with no gap.
- R9: The coefficient is c(k) = floor(PEAK·16·4·(k+1)·(54−k) / 55²) for k = 0..53. This value carries 4 fractional bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_valid | input | 1 | Upstream offers a chip |
| chip_in | input | 1 | Chip value (0 or 1) |
| chip_ready | output | 1 | Block will take a chip on this edge |
| out_valid | output | 1 | `out_word` holds a sample |
| out_word | output | 14 | Shaped sample, two's complement |

## Verification
The bench keeps the default window of three chips and the default of 18 samples per chip, so the table has only 8 patterns × 18 phases. The chip sequence used reaches every one of them. It raises the peak parameter to 4000. At that scale the all-equal patterns sum past the 14-bit range near the pulse centre, which brings clamping at both rails within reach. The stimulus mixes back-to-back chips with idle gaps, so streaming, stopping and restarting are all observed.

// File: rtl/cps_pkg.sv
package cps_pkg;

  // Parabolic coefficient with FRAC fractional bits (R9)
  function automatic int tap_coef(input int k, input int taps, input int peak, input int frac);
    longint num;
    num = longint'(peak) * (longint'(1) << frac) * 4 * longint'(k + 1) * longint'(taps - k);
    return int'(num / (longint'(taps + 1) * longint'(taps + 1)));
  endfunction

  // Round half up at FRAC, then clamp to OUT_W signed (R3)
  function automatic int round_sat(input int acc, input int frac, input int out_w);
    int r;
    int hi;
    int lo;
    r  = (frac > 0) ? ((acc + (1 <<< (frac - 1))) >>> frac) : acc;
    hi = (1 <<< (out_w - 1)) - 1;
    lo = -(1 <<< (out_w - 1));
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  // One table word: newest chip (MSB) uses segment 0; chip 0 -> +1, 1 -> -1 (R2)
  function automatic int shaped_word(input int pat, input int ph, input int win, input int sps,
                                     input int peak, input int frac, input int out_w);
    int acc;
    int c;
    acc = 0;
    for (int j = 0; j < win; j++) begin
      c = tap_coef(j * sps + ph, win * sps, peak, frac);
      if (((pat >> (win - 1 - j)) & 1) != 0) acc = acc - c;
      else acc = acc + c;
    end
    return round_sat(acc, frac, out_w);
  endfunction

endpackage

// File: rtl/chip_window.sv
module chip_window #(
  parameter int WIN = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           chip_in,
  output logic [WIN-1:0] win_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) win_q <= '0;
    else if (accept) win_q <= {chip_in, win_q[WIN-1:1]};
  end

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(win_q)); // R1

  AST_WIN_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> win_q[WIN-1] == $past(chip_in)); // R1

endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer #(
  parameter int SPS  = 18,
  localparam int PH_W = $clog2(SPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_valid,
  output logic            chip_ready,
  output logic            accept,
  output logic            busy,
  output logic            last_phase,
  output logic [PH_W-1:0] phase
);

  localparam logic [PH_W-1:0] LAST = PH_W'(SPS - 1);

  assign last_phase = busy && (phase == LAST);
  assign chip_ready = !busy || last_phase;
  assign accept     = chip_valid && chip_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      phase <= '0;
    end else if (last_phase) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (busy) begin
      phase <= phase + PH_W'(1);
    end
  end

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_phase) |=> (busy && phase == $past(phase) + PH_W'(1))); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !chip_valid) |=> !busy); // R6

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (last_phase && !chip_valid) |=> !busy); // R6

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_phase && chip_valid) |=> (busy && phase == '0)); // R8

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST); // R4

endmodule

// File: rtl/shape_lut.sv
module shape_lut
  import cps_pkg::*;
#(
  parameter int WIN   = 3,
  parameter int SPS   = 18,
  parameter int OUT_W = 14,
  parameter int PEAK  = 3000,
  parameter int FRAC  = 4,
  localparam int PH_W  = $clog2(SPS),
  localparam int NPAT  = 1 << WIN,
  localparam int DEPTH = NPAT * SPS,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [WIN-1:0]   win_q,
  input  logic [PH_W-1:0]  phase,
  output logic [OUT_W-1:0] word
);

  logic [OUT_W-1:0] rom [DEPTH];
  logic [IDX_W-1:0] idx;

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    for (genvar s = 0; s < SPS; s++) begin : g_ph
      assign rom[p*SPS + s] = OUT_W'(shaped_word(p, s, WIN, SPS, PEAK, FRAC, OUT_W));
    end
  end

  assign idx  = IDX_W'(win_q) * IDX_W'(SPS) + IDX_W'(phase);
  assign word = rom[idx];

endmodule

// File: rtl/chip_shaper.sv
module chip_shaper #(
  parameter int WIN   = 3,
  parameter int SPS   = 18,
  parameter int OUT_W = 14,
  parameter int PEAK  = 3000,
  parameter int FRAC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_valid,
  input  logic             chip_in,
  output logic             chip_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word
);

  localparam int PH_W = $clog2(SPS);

  logic            accept;
  logic            busy;
  logic            last_phase;
  logic [PH_W-1:0] phase;
  logic [WIN-1:0]  win_q;

  burst_sequencer #(.SPS(SPS)) u_seq (
    .clk, .rst_n, .chip_valid, .chip_ready, .accept, .busy, .last_phase, .phase
  );

  chip_window #(.WIN(WIN)) u_win (
    .clk, .rst_n, .accept, .chip_in, .win_q
  );

  shape_lut #(.WIN(WIN), .SPS(SPS), .OUT_W(OUT_W), .PEAK(PEAK), .FRAC(FRAC)) u_lut (
    .win_q, .phase, .word(out_word)
  );

  assign out_valid = busy;

  AST_PATTERN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_phase) |=> $stable(win_q)); // R1

  AST_READY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chip_ready) |-> (phase == PH_W'(SPS - 1))); // R5

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && chip_ready && win_q == '0)); // R7

endmodule

// File: tb/chip_shaper_test.sv
`timescale 1ns/1ps
module chip_shaper_test;

  localparam int PEAK = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_valid = 1'b0;
  logic        chip_in = 1'b0;
  logic        chip_ready;
  logic        out_valid;
  logic [13:0] out_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  bit n0 = 0, n1 = 0, n2 = 0;
  bit m_busy = 0;
  int m_ph = 0;
  bit seen [8];
  int sat_hits = 0;
  int b2b = 0;
  bit mon_on = 0;

  always #5 clk = ~clk;

  chip_shaper #(.PEAK(PEAK)) uut (
    .clk, .rst_n, .chip_valid, .chip_in, .chip_ready, .out_valid, .out_word
  );

  // R9 coefficient, R2 polarity, R3 rounding and clamp, restated in floating-free integer form
  function automatic int expect_word(bit a, bit b, bit c, int ph);
    longint s = 0;
    longint t;
    longint v;
    bit chips [3];
    chips[0] = a; chips[1] = b; chips[2] = c;
    for (int seg = 0; seg < 3; seg++) begin
      int k = 18 * seg + ph;
      t = (longint'(PEAK) * 64 * (k + 1) * (54 - k)) / 3025;
      s = chips[seg] ? s - t : s + t;
    end
    v = s + 8;
    if (v >= 0) v = v / 16;
    else v = -((-v + 15) / 16);
    if (v > 8191) v = 8191;
    if (v < -8192) v = -8192;
    return int'(v);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle monitor: sample at negedge, then predict the next edge
  always @(negedge clk) begin
    if (mon_on) begin
      int e;
      check(out_valid == m_busy, "R4 R6 out_valid", int'(out_valid), int'(m_busy));
      check(chip_ready == (!m_busy || m_ph == 17), "R5 chip_ready",
            int'(chip_ready), int'(!m_busy || m_ph == 17));
      if (m_busy) begin
        e = expect_word(n0, n1, n2, m_ph);
        check($signed(out_word) == e, "R3 out_word", int'($signed(out_word)), e);
        seen[{n0, n1, n2}] = 1;
        if (e == 8191 || e == -8192) sat_hits++;
      end
      if (chip_valid && chip_ready) begin
        if (m_busy && m_ph == 17) b2b++;
        n2 = n1; n1 = n0; n0 = chip_in;
        m_busy = 1; m_ph = 0;
      end else if (m_busy) begin
        if (m_ph == 17) begin m_busy = 0; m_ph = 0; end
        else m_ph++;
      end
    end
  end

  task automatic send(input bit b, input int gap);
    @(posedge clk); #1;
    chip_valid = 1'b1;
    chip_in = b;
    do @(negedge clk); while (!chip_ready);
    @(posedge clk); #1;
    chip_valid = 1'b0;
    repeat (gap) @(posedge clk);
  endtask

  initial begin
    bit [6:0] lfsr = 7'h5B;
    bit db [10] = '{0, 0, 0, 1, 0, 1, 1, 1, 0, 0};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
    check(chip_ready == 1'b1, "R7 chip_ready after reset", int'(chip_ready), 1);
    mon_on = 1;
    repeat (4) @(posedge clk);
    // R1 R8: streaming sequence visiting every window pattern
    foreach (db[i]) send(db[i], 0);
    repeat (25) @(posedge clk);
    // R6: isolated chips with idle gaps
    send(1'b1, 30);
    send(1'b1, 3);
    send(1'b0, 22);
    // mixed stream
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      send(lfsr[0], (i % 7 == 3) ? 20 : 0);
    end
    repeat (40) @(posedge clk);
    mon_on = 0;
    for (int p = 0; p < 8; p++)
      check(seen[p], "R1 window pattern reached", int'(seen[p]), 1);
    check(sat_hits > 0, "R3 clamp reached", sat_hits, 1);
    check(b2b > 0, "R8 back-to-back bursts", b2b, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule